// File: doc/BRIEF.md
# Transmit Byte Queue with Free-Space Status

This block is the byte queue that sits between a serial register interface and a radio transmitter. The serial side pushes payload bytes one at a time. The transmitter pulls them out in the same order. For every byte the serial side presents, the block reports how many entries were free before that byte is stored. The interface logic merges this count into the status byte it shifts back, so software can pace its writes and notice trouble without a separate read.

The write side and the read side are both valid/ready streams. On the write side, `wr_ready` is low only while the queue holds its full capacity. The serial side cannot stall mid-byte, so a beat offered while `wr_ready` is low is discarded, not held. On the read side, `rd_valid` is high whenever at least one byte is stored. The transmitter takes the byte on `rd_data` in any cycle where it raises `rd_ready` while `rd_valid` is high. If it raises `rd_ready` while the queue is empty, that is an underflow. It sets a sticky flag.

Two events clear the queue. The first is a flush request, which takes effect only while the radio is idle or parked after an underflow. The second is the radio entering its sleep state. Both clearing events take precedence over any transfer in the same cycle.

Top module: `tx_fifo_status`

## Requirements
- R1: Bytes leave on `rd_data` in the order they were accepted. `rd_valid` is high exactly when one or more bytes are stored, and `rd_data` shows the oldest stored byte.
- R2: `wr_ready` is low exactly when the stored count equals DEPTH. A write offered while `wr_ready` is low is discarded and leaves the contents unchanged.
- R3: The queue holds DEPTH bytes, 64 by default. After 64 accepted writes with no reads, it is full.
- R4: `wr_free` shows the number of free entries as they stood before the write in the current cycle. It is derived only from the registered fill level. It saturates at 15 whenever 15 or more entries are free.
- R5: While the last byte that still fits is being offered, `wr_free` reads 1. While the queue is full, `wr_free` reads 0.
- R6: A flush request with `radio_state` equal to 1 (idle) or 3 (parked after underflow) empties the queue at the next clock edge and clears `tx_underflow`.
- R7: A flush request in any other `radio_state` has no effect. This includes 2 (transmitting), 4 and 5.
- R8: A change of `radio_state` into 0 (sleep) from any other value empties the queue at the next edge. Bytes written while the state stays at 0 are kept.
- R9: Raising `rd_ready` while `rd_valid` is low sets `tx_underflow` from the next cycle on. The flag stays set, including across sleep entry, until an honoured flush clears it.
- R10: A write or a read in the same cycle as an honoured flush or a sleep entry is discarded.
- R11: After reset, the queue is empty, `wr_ready` is 1, `wr_free` is 15 and `tx_underflow` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Queue can accept a byte |
| wr_data | input | 8 | Byte to store |
| wr_free | output | 4 | Free entries before the current write, saturated at 15 |
| rd_valid | output | 1 | A stored byte is available |
| rd_ready | input | 1 | Transmitter takes a byte |
| rd_data | output | 8 | Oldest stored byte |
| flush_req | input | 1 | Request to empty the queue |
| radio_state | input | 3 | Radio state: 0 sleep, 1 idle, 2 transmit, 3 parked after underflow, 4 and 5 other |
| tx_underflow | output | 1 | Sticky underflow flag |

## Verification
Some properties are checked on every cycle: the fill level never exceeds DEPTH, a full queue never grows, any clear leaves the queue empty at the next edge, the underflow flag is set by an empty read and holds until a flush, a flush while transmitting leaves the fill level unchanged, and a full queue reports zero free entries. Other behaviour needs the bench's scenarios. These include byte ordering across mixed reads and writes, the exact free count as the queue fills to its last slot, the retention of bytes written while the radio stays asleep, and transfers discarded in a clearing cycle.

// File: rtl/tfq_pkg.sv
package tfq_pkg;

  typedef enum logic [2:0] {
    RS_SLEEP   = 3'd0,
    RS_IDLE    = 3'd1,
    RS_TX      = 3'd2,
    RS_TX_UFL  = 3'd3,
    RS_CAL     = 3'd4,
    RS_SETTLE  = 3'd5
  } radio_state_e;

  function automatic logic flush_allowed(input logic [2:0] st);
    return (st == RS_IDLE) || (st == RS_TX_UFL);
  endfunction

endpackage

// File: rtl/tfq_clear_ctl.sv
module tfq_clear_ctl
  import tfq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush_req,
  input  logic [2:0] radio_state,
  output logic       flush_ok,
  output logic       clear_all
);

  logic in_sleep_q;
  logic is_sleep;
  logic sleep_entry;

  assign is_sleep    = (radio_state == RS_SLEEP);
  assign sleep_entry = is_sleep && !in_sleep_q;
  assign flush_ok    = flush_req && flush_allowed(radio_state);
  assign clear_all   = flush_ok || sleep_entry;

  always_ff @(posedge clk) begin
    if (!rst_n) in_sleep_q <= 1'b0;
    else        in_sleep_q <= is_sleep;
  end

  // R8: remaining asleep never produces a further clear
  p_sleep_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sleep && $past(is_sleep) && !flush_req) |-> !clear_all);

endmodule

// File: rtl/tfq_ptrs.sv
module tfq_ptrs #(
  parameter int DEPTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             clear,
  output logic             do_push,
  output logic             do_pop,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] fill_cnt,
  output logic             full,
  output logic             empty
);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (fill_cnt == CNT_W'(DEPTH));
  assign empty   = (fill_cnt == '0);
  assign do_push = push_req && !full && !clear;
  assign do_pop  = pop_req && !empty && !clear;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill_cnt <= '0;
    end else if (clear) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill_cnt <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
      fill_cnt <= fill_cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CNT_W'(DEPTH));

  p_full_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req) |=> (fill_cnt <= $past(fill_cnt)));

  p_clear_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> empty);

endmodule

// File: rtl/tfq_store.sv
module tfq_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] wr_ptr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/tfq_status.sv
module tfq_status #(
  parameter int DEPTH  = 64,
  parameter int FREE_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int SAT   = (1 << FREE_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  fill_cnt,
  input  logic              empty,
  input  logic              rd_ready,
  input  logic              flush_ok,
  output logic [FREE_W-1:0] wr_free,
  output logic              underflow
);

  logic [CNT_W:0] free_raw;

  assign free_raw = (CNT_W + 1)'(DEPTH) - {1'b0, fill_cnt};

  generate
    if (DEPTH > SAT) begin : g_sat
      assign wr_free = (free_raw > (CNT_W + 1)'(SAT)) ? FREE_W'(SAT)
                                                     : FREE_W'(free_raw);
    end else begin : g_nosat
      assign wr_free = FREE_W'(free_raw);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)                     underflow <= 1'b0;
    else if (flush_ok)              underflow <= 1'b0;
    else if (rd_ready && empty)     underflow <= 1'b1;
  end

  p_uf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && empty && !flush_ok) |=> underflow);

  p_uf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !flush_ok) |=> underflow);

endmodule

// File: rtl/tx_fifo_status.sv
module tx_fifo_status
  import tfq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int WIDTH  = 8,
  parameter int FREE_W = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [FREE_W-1:0] wr_free,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [WIDTH-1:0]  rd_data,
  input  logic              flush_req,
  input  logic [2:0]        radio_state,
  output logic              tx_underflow
);

  logic             flush_ok;
  logic             clear_all;
  logic             do_push;
  logic             do_pop;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] fill_cnt;
  logic             full;
  logic             empty;

  tfq_clear_ctl u_clr (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_req   (flush_req),
    .radio_state (radio_state),
    .flush_ok    (flush_ok),
    .clear_all   (clear_all)
  );

  tfq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (wr_valid),
    .pop_req  (rd_ready),
    .clear    (clear_all),
    .do_push  (do_push),
    .do_pop   (do_pop),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .fill_cnt (fill_cnt),
    .full     (full),
    .empty    (empty)
  );

  tfq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .we      (do_push),
    .wr_ptr  (wr_ptr),
    .wr_data (wr_data),
    .rd_ptr  (rd_ptr),
    .rd_data (rd_data)
  );

  tfq_status #(.DEPTH(DEPTH), .FREE_W(FREE_W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_cnt  (fill_cnt),
    .empty     (empty),
    .rd_ready  (rd_ready),
    .flush_ok  (flush_ok),
    .wr_free   (wr_free),
    .underflow (tx_underflow)
  );

  assign wr_ready = !full;
  assign rd_valid = !empty;

  p_full_free_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> (wr_free == '0));

  p_flush_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_req && radio_state == RS_TX && !wr_valid && !rd_ready)
      |=> (fill_cnt == $past(fill_cnt)));

endmodule

// File: tb/tx_fifo_status_test.sv
module tx_fifo_status_test;

  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic [3:0] wr_free;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       flush_req = 1'b0;
  logic [2:0] radio_state = 3'd1;
  logic       tx_underflow;

  int n_vec = 0;
  int n_err = 0;
  logic [7:0] q[$];
  logic exp_uf = 1'b0;
  logic exp_clear = 1'b0;
  logic [2:0] prev_st = 3'd1;
  logic done = 1'b0;

  always #10 clk = ~clk;

  tx_fifo_status uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_data      (wr_data),
    .wr_free      (wr_free),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_data      (rd_data),
    .flush_req    (flush_req),
    .radio_state  (radio_state),
    .tx_underflow (tx_underflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] sat_free(input int sz);
    return ((DEPTH - sz) >= 15) ? 4'd15 : 4'(DEPTH - sz);
  endfunction

  // Driver: one clock cycle of stimulus, updating the scoreboard model.
  task automatic cyc(input logic wv, input logic [7:0] wd, input logic rr,
                     input logic fl, input logic [2:0] st);
    int  sz;
    logic fl_ok;
    logic clr;
    @(posedge clk);
    #5;
    sz = q.size();
    chk("R4 free count before write", 32'(wr_free), 32'(sat_free(sz)));
    chk("R2 write ready", 32'(wr_ready), 32'(sz < DEPTH));
    chk("R1 read valid", 32'(rd_valid), 32'(sz > 0));
    chk("R9 underflow flag", 32'(tx_underflow), 32'(exp_uf));
    if (wv && sz == DEPTH - 1) chk("R5 last slot reports one", 32'(wr_free), 32'd1);
    if (sz == DEPTH) chk("R5 full reports zero", 32'(wr_free), 32'd0);
    wr_valid    = wv;
    wr_data     = wd;
    rd_ready    = rr;
    flush_req   = fl;
    radio_state = st;
    fl_ok = fl && (st == 3'd1 || st == 3'd3);
    clr   = fl_ok || (st == 3'd0 && prev_st != 3'd0);
    exp_clear = clr;
    if (clr) q.delete();
    if (fl_ok) exp_uf = 1'b0;
    else if (rr && sz == 0) exp_uf = 1'b1;
    if (wv && sz < DEPTH && !clr) q.push_back(wd);
    prev_st = st;
  endtask

  // Monitor: compares each byte taken by the transmitter with the scoreboard.
  always @(negedge clk) begin
    if (rst_n && !done && rd_valid && rd_ready && !exp_clear) begin
      if (q.size() == 0) begin
        chk("R1 unexpected byte", 32'(rd_data), 32'hFFFF);
      end else begin
        chk("R1 byte order", 32'(rd_data), 32'(q[0]));
        void'(q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R11 reset state
    chk("R11 reset ready", 32'(wr_ready), 32'd1);
    chk("R11 reset free", 32'(wr_free), 32'd15);
    chk("R11 reset valid", 32'(rd_valid), 32'd0);
    chk("R11 reset underflow", 32'(tx_underflow), 32'd0);

    // R3 fill to depth while transmitting; extra writes dropped (R2)
    for (int i = 0; i < 70; i++) cyc(1'b1, 8'(i * 3 + 1), 1'b0, 1'b0, 3'd2);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 3'd2);
    chk("R3 full after depth writes", 32'(wr_ready), 32'd0);

    // R7 flush while transmitting or calibrating is ignored
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 3'd2);
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 3'd4);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 3'd2);
    chk("R7 contents kept after ignored flush", 32'(rd_valid), 32'd1);
    chk("R7 still full", 32'(wr_free), 32'd0);

    // R1 read with simultaneous writes, then drain
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 3'd2);
    for (int i = 0; i < 10; i++) cyc(1'b1, 8'(8'hA0 + i), 1'b1, 1'b0, 3'd2);
    for (int i = 0; i < 70; i++) cyc(1'b0, 8'h00, 1'b1, 1'b0, 3'd2);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 3'd2);
    chk("R9 empty read raised underflow", 32'(tx_underflow), 32'd1);

    // R8 sleep entry clears, flag stays; bytes written while asleep kept
    cyc(1'b1, 8'h11, 1'b0, 1'b0, 3'd2);
    cyc(1'b1, 8'h22, 1'b0, 1'b0, 3'd2);
    cyc(1'b1, 8'h33, 1'b0, 1'b0, 3'd0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 3'd0);
    chk("R8 sleep entry emptied", 32'(rd_valid), 32'd0);
    chk("R9 flag survives sleep", 32'(tx_underflow), 32'd1);
    cyc(1'b1, 8'h44, 1'b0, 1'b0, 3'd0);
    cyc(1'b1, 8'h55, 1'b0, 1'b0, 3'd0);
    cyc(1'b1, 8'h66, 1'b0, 1'b0, 3'd0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 3'd1);
    chk("R8 bytes kept while asleep", 32'(wr_free), 32'd15);
    chk("R8 data present after sleep writes", 32'(rd_valid), 32'd1);
    for (int i = 0; i < 3; i++) cyc(1'b0, 8'h00, 1'b1, 1'b0, 3'd1);

    // R6 R10 flush in parked state with a write in the same cycle
    for (int i = 0; i < 5; i++) cyc(1'b1, 8'(8'h70 + i), 1'b0, 1'b0, 3'd2);
    cyc(1'b1, 8'h99, 1'b0, 1'b1, 3'd3);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 3'd3);
    chk("R10 write dropped in flush cycle", 32'(rd_valid), 32'd0);
    chk("R6 flush clears underflow", 32'(tx_underflow), 32'd0);

    // R10 read in the same cycle as an idle flush is discarded
    cyc(1'b1, 8'h5A, 1'b0, 1'b0, 3'd1);
    cyc(1'b1, 8'hA5, 1'b0, 1'b0, 3'd1);
    cyc(1'b0, 8'h00, 1'b1, 1'b1, 3'd1);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 3'd1);
    chk("R6 idle flush emptied", 32'(wr_free), 32'd15);
    chk("R10 no underflow from cleared read", 32'(tx_underflow), 32'd0);

    // R8 R10 sleep entry with a write in the same cycle
    for (int i = 0; i < 20; i++) cyc(1'b1, 8'(i + 8'hC0), 1'b0, 1'b0, 3'd2);
    cyc(1'b1, 8'hEE, 1'b0, 1'b0, 3'd0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 3'd0);
    chk("R10 write dropped at sleep entry", 32'(rd_valid), 32'd0);
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 3'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

endmodule